// File: doc/BRIEF.md
# Three-Wire Control Register Interface

This block receives write-only control traffic on three asynchronous lines, a mode line, a serial clock line and a serial data line, and keeps the settings that a downstream audio datapath reads. Each transfer begins with an address byte that is sent while the mode line is low. The address byte names the device and picks one of two register groups. The data bytes that follow are sent while the mode line is high. The top bits of each data byte choose which register in the chosen group is written. The chosen group stays in force until another address byte arrives.

All three lines pass through synchronisers into the system clock domain. Bits are shifted in least significant bit first, on each rising edge of the serial clock. A byte takes effect only after all eight of its bits are in. A select input chooses between the programmed register values and a fixed set of defaults. In the default (static) set, the mute and de-emphasis outputs are driven from dedicated pins.

Top module: `ctl3w_regif`

## Requirements
- R1: A byte is eight bits shifted LSB first, one bit on each rising edge of `l_clk`. A byte completed while `l_mode` is low is an address byte. Its bits 7:2 must equal the device address, 6'b000101 by default, for the device to be selected.
- R2: In a matching address byte, bits 1:0 set to 2'b00 select the data group and 2'b10 selects the status group. The codes 2'b01 and 2'b11 leave the interface deselected.
- R3: An address byte whose bits 7:2 do not match deselects the interface. Every data byte after it leaves all registers unchanged until a matching address byte arrives.
- R4: Once a group is selected, it stays in force for any number of data bytes, including across mode-line halt pulses, until the next address byte.
- R5: A register changes only when the eighth bit of a byte arrives. Any change on `l_mode` clears the bit count, so a partial byte is discarded and never written.
- R6: In the data group, a data byte with bits 7:6 set to 00 writes bits 5:0 to right volume, and 01 writes bits 5:0 to left volume. With bits 7:6 at 10, bits 4:0 go to bass, and with 11 they go to treble. Bit 5 is ignored for bass and treble.
- R7: In the status group, a byte with bit 7 at 0 writes the tone mode from bits 6:5, de-emphasis from bit 4, the right routing code from bits 3:2 and the left routing code from bits 1:0. A byte with bit 7 at 1 is ignored.
- R8: While `ctl_sel` is low, the outputs show the static defaults: volumes 0, bass 0, treble 0, tone mode 00, left route 2'b10 and right route 2'b01. De-emphasis follows `pin_deemph`, and the mutes follow `pin_mute_l` and `pin_mute_r`. The registers themselves are left untouched.
- R9: While `ctl_sel` is high, a channel's mute output is 1 exactly when its routing code is 2'b00. The routing codes are 2'b00 mute, 2'b01 right source, 2'b10 left source and 2'b11 average.
- R10: After reset, the registers hold volume 0, bass 0, treble 0, tone mode 00, de-emphasis off, left route 2'b10 and right route 2'b01, with the interface deselected.
- R11: A register write is visible at the outputs no later than 5 `clk` cycles after the eighth rising edge of `l_clk`. The outputs do not change at any other time while `ctl_sel` and the pins are steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_sel | input | 1 | 1 selects the programmed registers, 0 selects the static defaults |
| l_mode | input | 1 | Serial mode line (low during an address byte) |
| l_clk | input | 1 | Serial bit clock |
| l_data | input | 1 | Serial data line |
| pin_mute_l | input | 1 | Left mute used in static mode |
| pin_mute_r | input | 1 | Right mute used in static mode |
| pin_deemph | input | 1 | De-emphasis enable used in static mode |
| vol_r | output | 6 | Right volume code |
| vol_l | output | 6 | Left volume code |
| bass | output | 5 | Bass boost code |
| treble | output | 5 | Treble code |
| tone_mode | output | 2 | Tone filter mode |
| deemph | output | 1 | De-emphasis enable |
| route_l | output | 2 | Left channel routing code |
| route_r | output | 2 | Right channel routing code |
| mute_l | output | 1 | Left mute |
| mute_r | output | 1 | Right mute |

## Verification
Some internal faults never show on any output until a later data byte arrives. Examples are a selection flag left in the wrong state, a group bit stuck, or a bit counter that is off by one. The bench therefore follows each address byte with data bytes whose value differs from what the registers already hold, so that a fault shows as a wrong register within five cycles of that byte. A behavioural model of the registers is compared with the outputs on every clock outside the short write-latency window. This catches writes that land early, writes that land in the wrong place, and writes that should have been dropped.

// File: rtl/ctl3w_pkg.sv
package ctl3w_pkg;
   localparam int BYTE_W = 8;
   localparam int VOL_W  = 6;
   localparam int TONE_W = 5;
   localparam int DEV_W  = 6;
   localparam int CNT_W  = $clog2(BYTE_W);

   typedef enum logic [1:0] {
      ROUTE_MUTE  = 2'b00,
      ROUTE_RIGHT = 2'b01,
      ROUTE_LEFT  = 2'b10,
      ROUTE_AVG   = 2'b11
   } route_e;

   typedef struct packed {
      logic [VOL_W-1:0]  vol_r;
      logic [VOL_W-1:0]  vol_l;
      logic [TONE_W-1:0] bass;
      logic [TONE_W-1:0] treble;
      logic [1:0]        tone_mode;
      logic              deemph;
      route_e            route_l;
      route_e            route_r;
   } ctl_regs_t;

   localparam ctl_regs_t REGS_DEFAULT = '{
      vol_r: '0, vol_l: '0, bass: '0, treble: '0, tone_mode: 2'b00,
      deemph: 1'b0, route_l: ROUTE_LEFT, route_r: ROUTE_RIGHT};
endpackage

// File: rtl/ctl3w_sync.sv
module ctl3w_sync #(
   parameter int               WIDTH   = 3,
   parameter int               STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("ctl3w_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("ctl3w_sync: WIDTH must be at least 1");
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= {STAGES{RST_VAL[i]}};
         else        chain <= {chain[STAGES-2:0], d[i]};
      end
      assign q[i] = chain[STAGES-1];
   end
endmodule

// File: rtl/ctl3w_deser.sv
module ctl3w_deser
   import ctl3w_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_s,
   input  logic              clk_s,
   input  logic              data_s,
   output logic              byte_vld,
   output logic              byte_addr,
   output logic [BYTE_W-1:0] byte_val
);
   logic              mode_q, clk_q;
   logic [CNT_W-1:0]  cnt;
   logic [BYTE_W-1:0] shreg;
   logic              rise, mchg;
   logic [BYTE_W-1:0] next_sh;

   assign rise    = clk_s & ~clk_q;
   assign mchg    = mode_s ^ mode_q;
   assign next_sh = {data_s, shreg[BYTE_W-1:1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q    <= 1'b1;
         clk_q     <= 1'b0;
         cnt       <= '0;
         shreg     <= '0;
         byte_vld  <= 1'b0;
         byte_addr <= 1'b0;
         byte_val  <= '0;
      end else begin
         mode_q   <= mode_s;
         clk_q    <= clk_s;
         byte_vld <= 1'b0;
         if (mchg) begin
            cnt <= '0;
         end else if (rise) begin
            shreg <= next_sh;
            if (cnt == CNT_W'(BYTE_W-1)) begin
               cnt       <= '0;
               byte_vld  <= 1'b1;
               byte_addr <= ~mode_s;
               byte_val  <= next_sh;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/ctl3w_regfile.sv
module ctl3w_regfile
   import ctl3w_pkg::*;
#(
   parameter logic [DEV_W-1:0] DEV_ADDR = 6'b000101
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              byte_vld,
   input  logic              byte_addr,
   input  logic [BYTE_W-1:0] byte_val,
   output ctl_regs_t         regs,
   output logic              sel_valid,
   output logic              sel_status
);
   logic dev_hit;
   assign dev_hit = (byte_val[BYTE_W-1:2] == DEV_ADDR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         regs       <= REGS_DEFAULT;
         sel_valid  <= 1'b0;
         sel_status <= 1'b0;
      end else if (byte_vld) begin
         if (byte_addr) begin
            sel_valid  <= dev_hit & ~byte_val[0];
            sel_status <= byte_val[1];
         end else if (sel_valid) begin
            if (!sel_status) begin
               unique case (byte_val[7:6])
                  2'b00: regs.vol_r  <= byte_val[VOL_W-1:0];
                  2'b01: regs.vol_l  <= byte_val[VOL_W-1:0];
                  2'b10: regs.bass   <= byte_val[TONE_W-1:0];
                  2'b11: regs.treble <= byte_val[TONE_W-1:0];
               endcase
            end else if (!byte_val[7]) begin
               regs.tone_mode <= byte_val[6:5];
               regs.deemph    <= byte_val[4];
               regs.route_r   <= route_e'(byte_val[3:2]);
               regs.route_l   <= route_e'(byte_val[1:0]);
            end
         end
      end
   end
endmodule

// File: rtl/ctl3w_regif.sv
module ctl3w_regif
   import ctl3w_pkg::*;
#(
   parameter logic [DEV_W-1:0] DEV_ADDR    = 6'b000101,
   parameter int               SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_sel,
   input  logic              l_mode,
   input  logic              l_clk,
   input  logic              l_data,
   input  logic              pin_mute_l,
   input  logic              pin_mute_r,
   input  logic              pin_deemph,
   output logic [VOL_W-1:0]  vol_r,
   output logic [VOL_W-1:0]  vol_l,
   output logic [TONE_W-1:0] bass,
   output logic [TONE_W-1:0] treble,
   output logic [1:0]        tone_mode,
   output logic              deemph,
   output logic [1:0]        route_l,
   output logic [1:0]        route_r,
   output logic              mute_l,
   output logic              mute_r
);
   logic              mode_s, clk_s, data_s;
   logic              byte_vld, byte_addr;
   logic [BYTE_W-1:0] byte_val;
   ctl_regs_t         regs;
   logic              sel_valid, sel_status;

   ctl3w_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .d({l_mode, l_clk, l_data}),
      .q({mode_s, clk_s, data_s}));

   ctl3w_deser u_deser (
      .clk(clk), .rst_n(rst_n),
      .mode_s(mode_s), .clk_s(clk_s), .data_s(data_s),
      .byte_vld(byte_vld), .byte_addr(byte_addr), .byte_val(byte_val));

   ctl3w_regfile #(.DEV_ADDR(DEV_ADDR)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .byte_vld(byte_vld), .byte_addr(byte_addr), .byte_val(byte_val),
      .regs(regs), .sel_valid(sel_valid), .sel_status(sel_status));

   always_comb begin
      if (ctl_sel) begin
         vol_r     = regs.vol_r;
         vol_l     = regs.vol_l;
         bass      = regs.bass;
         treble    = regs.treble;
         tone_mode = regs.tone_mode;
         deemph    = regs.deemph;
         route_l   = regs.route_l;
         route_r   = regs.route_r;
         mute_l    = (regs.route_l == ROUTE_MUTE);
         mute_r    = (regs.route_r == ROUTE_MUTE);
      end else begin
         vol_r     = '0;
         vol_l     = '0;
         bass      = '0;
         treble    = '0;
         tone_mode = 2'b00;
         deemph    = pin_deemph;
         route_l   = ROUTE_LEFT;
         route_r   = ROUTE_RIGHT;
         mute_l    = pin_mute_l;
         mute_r    = pin_mute_r;
      end
   end
endmodule

// File: rtl/ctl3w_chk.sv
module ctl3w_chk
   import ctl3w_pkg::*;
#(
   parameter logic [DEV_W-1:0] DEV_ADDR = 6'b000101
) (
   input logic              clk,
   input logic              rst_n,
   input logic              byte_vld,
   input logic              byte_addr,
   input logic [BYTE_W-1:0] byte_val,
   input ctl_regs_t         regs,
   input logic              sel_valid,
   input logic              sel_status
);
   // R5
   hold_no_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !byte_vld |=> $stable(regs));
   // R5
   byte_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      byte_vld |=> !byte_vld);
   // R3
   deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_vld && byte_addr && byte_val[BYTE_W-1:2] != DEV_ADDR) |=> !sel_valid);
   // R3
   ignore_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_vld && !byte_addr && !sel_valid) |=> $stable(regs));
   // R4
   persist_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_vld && !byte_addr) |=> ($stable(sel_valid) && $stable(sel_status)));
   // R7
   status_msb_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_vld && !byte_addr && sel_status && byte_val[7]) |=> $stable(regs));
endmodule

bind ctl3w_regif ctl3w_chk #(.DEV_ADDR(DEV_ADDR)) u_chk (
   .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_addr(byte_addr),
   .byte_val(byte_val), .regs(regs), .sel_valid(sel_valid),
   .sel_status(sel_status));

// File: tb/tb_ctl3w_regif.sv
`timescale 1ns/1ps
module tb_ctl3w_regif;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ctl_sel = 1'b1, l_mode = 1'b1, l_clk = 1'b0, l_data = 1'b0;
   logic pin_mute_l = 1'b0, pin_mute_r = 1'b0, pin_deemph = 1'b0;
   logic [5:0] vol_r, vol_l;
   logic [4:0] bass, treble;
   logic [1:0] tone_mode, route_l, route_r;
   logic deemph, mute_l, mute_r;

   always #2 clk = ~clk;

   ctl3w_regif dut (
      .clk(clk), .rst_n(rst_n), .ctl_sel(ctl_sel), .l_mode(l_mode),
      .l_clk(l_clk), .l_data(l_data), .pin_mute_l(pin_mute_l),
      .pin_mute_r(pin_mute_r), .pin_deemph(pin_deemph),
      .vol_r(vol_r), .vol_l(vol_l), .bass(bass), .treble(treble),
      .tone_mode(tone_mode), .deemph(deemph), .route_l(route_l),
      .route_r(route_r), .mute_l(mute_l), .mute_r(mute_r));

   // behavioural reference state
   int m_vr = 0, m_vl = 0, m_bb = 0, m_tr = 0, m_md = 0, m_de = 0;
   int m_rl = 2, m_rr = 1;
   bit m_sel = 0, m_st = 0;
   int n_tests = 0, n_fail = 0, mism = 0;
   int cyc = 0, settle_until = 0;
   bit run = 0, done = 0;

   wire [30:0] dut_vec = {vol_r, vol_l, bass, treble, tone_mode, deemph,
                          route_l, route_r, mute_l, mute_r};

   function automatic logic [30:0] exp_vec();
      if (ctl_sel)
         return {6'(m_vr), 6'(m_vl), 5'(m_bb), 5'(m_tr), 2'(m_md), 1'(m_de),
                 2'(m_rl), 2'(m_rr), 1'(m_rl == 0), 1'(m_rr == 0)};
      return {6'd0, 6'd0, 5'd0, 5'd0, 2'd0, pin_deemph, 2'b10, 2'b01,
              pin_mute_l, pin_mute_r};
   endfunction

   function automatic void model_byte(bit is_addr, logic [7:0] b);
      if (is_addr) begin
         m_sel = (b[7:2] == 6'b000101) && !b[0];
         m_st  = b[1];
      end else if (m_sel) begin
         if (!m_st) begin
            case (b[7:6])
               2'b00: m_vr = int'(b[5:0]);
               2'b01: m_vl = int'(b[5:0]);
               2'b10: m_bb = int'(b[4:0]);
               default: m_tr = int'(b[4:0]);
            endcase
         end else if (!b[7]) begin
            m_md = int'(b[6:5]); m_de = int'(b[4]);
            m_rr = int'(b[3:2]); m_rl = int'(b[1:0]);
         end
      end
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk)
      if (rst_n && run && cyc >= settle_until && dut_vec !== exp_vec())
         mism <= mism + 1;

   task automatic wait_cyc(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic send_byte(bit is_addr, logic [7:0] b, int nbits, bit lat);
      if (is_addr) begin l_mode = 1'b0; wait_cyc(8); end
      for (int i = 0; i < nbits; i++) begin
         l_data = b[i];
         wait_cyc(4);
         l_clk = 1'b1;
         if (i == 7) begin
            model_byte(is_addr, b);
            settle_until = cyc + 8;
            if (lat) begin
               repeat (4) @(posedge clk);
               @(negedge clk);
               chk("R11 write latency", 32'(dut_vec), 32'(exp_vec()));
               @(posedge clk); #1;
            end
         end
         wait_cyc(4);
         l_clk = 1'b0;
      end
      if (is_addr) l_mode = 1'b1;
      wait_cyc(10);
   endtask

   task automatic halt_pulse();
      l_mode = 1'b0; wait_cyc(8);
      l_mode = 1'b1; wait_cyc(8);
   endtask

   task automatic sample();
      @(negedge clk);
   endtask

   initial begin
      wait_cyc(5);
      rst_n = 1'b1;
      wait_cyc(4);
      run = 1;
      sample();
      chk("R10 reset state", 32'(dut_vec), 32'(exp_vec()));
      chk("R10 reset routes", 32'({route_l, route_r}), 32'(4'b1001));

      // static defaults with pins
      #1; ctl_sel = 1'b0; pin_mute_l = 1'b1; pin_deemph = 1'b1;
      sample();
      chk("R8 static defaults", 32'(dut_vec), 32'(exp_vec()));
      chk("R8 static mute pin", 32'({mute_l, mute_r, deemph}), 32'(3'b101));
      #1; ctl_sel = 1'b1; pin_mute_l = 1'b0; pin_deemph = 1'b0;

      // data group writes
      send_byte(1, 8'h14, 8, 0);
      send_byte(0, 8'h2A, 8, 1);
      sample(); chk("R1 R6 right volume", 32'(vol_r), 32'd42);
      send_byte(0, 8'h55, 8, 0);
      sample(); chk("R6 left volume", 32'(vol_l), 32'h15);
      send_byte(0, 8'hB3, 8, 0);
      sample(); chk("R6 bass with bit5 ignored", 32'(bass), 32'h13);
      send_byte(0, 8'hCA, 8, 0);
      sample(); chk("R6 treble", 32'(treble), 32'h0A);
      halt_pulse();
      send_byte(0, 8'h3F, 8, 0);
      sample(); chk("R4 selection persists after halt", 32'(vol_r), 32'h3F);

      // status group writes
      send_byte(1, 8'h16, 8, 0);
      send_byte(0, 8'h53, 8, 0);
      sample();
      chk("R7 status fields", 32'({tone_mode, deemph, route_r, route_l}),
          32'(7'b10_1_00_11));
      chk("R9 mute from route 00", 32'({mute_l, mute_r}), 32'(2'b01));
      chk("R2 status group leaves volumes", 32'(vol_r), 32'h3F);
      send_byte(0, 8'hAC, 8, 0);
      sample(); chk("R7 status bit7 set ignored", 32'(dut_vec), 32'(exp_vec()));
      chk("R7 status bit7 set keeps mode", 32'(tone_mode), 32'd2);

      // wrong device address
      send_byte(1, 8'h24, 8, 0);
      send_byte(0, 8'h01, 8, 0);
      sample(); chk("R3 mismatched address ignored", 32'(vol_r), 32'h3F);
      send_byte(0, 8'h06, 8, 0);
      sample(); chk("R3 still deselected", 32'({route_r, route_l}), 32'(4'b0011));

      // unused type code
      send_byte(1, 8'h15, 8, 0);
      send_byte(0, 8'h07, 8, 0);
      sample(); chk("R2 type 01 deselects", 32'(vol_r), 32'h3F);

      // partial byte then full byte
      send_byte(1, 8'h14, 8, 0);
      send_byte(0, 8'h07, 5, 0);
      halt_pulse();
      sample(); chk("R5 partial byte not written", 32'(vol_r), 32'h3F);
      send_byte(0, 8'h05, 8, 0);
      sample(); chk("R5 byte after abort", 32'(vol_r), 32'h05);

      // static override keeps registers
      #1; ctl_sel = 1'b0; pin_mute_r = 1'b1;
      sample(); chk("R8 static overrides registers", 32'(dut_vec), 32'(exp_vec()));
      #1; ctl_sel = 1'b1; pin_mute_r = 1'b0;
      sample(); chk("R8 registers kept", 32'({vol_r, vol_l, bass, treble}),
                    32'({6'h05, 6'h15, 5'h13, 5'h0A}));

      // routing back to straight
      send_byte(1, 8'h16, 8, 0);
      send_byte(0, 8'h06, 8, 0);
      sample();
      chk("R9 straight routing unmuted",
          32'({route_l, route_r, mute_l, mute_r}), 32'(6'b10_01_0_0));

      run = 0;
      chk("R11 R6 R7 continuous compare mismatches", 32'(mism), 32'd0);
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #(4 * 150000);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule